// File: doc/BRIEF.md
# Variable-Rate Sample Request Pacer

This block paces on-demand audio sample transfers across a serial link whose frame rate never changes from 48000 frames per second. It keeps one programmable rate for the playback direction and one for the capture direction. On every frame strobe it decides whether playback asks the controller for a new sample in that frame, and whether capture has a fresh sample (left and right together) to hand over. Over time, the number of such frames matches the programmed rate.

Software sets a rate by writing its value in hertz. If the value written is not one of the supported rates, the block stores the closest supported rate instead, and reads return that stored value. Each direction has a fractional accumulator. On each frame strobe the accumulator adds the rate. When the sum reaches the link rate, the link rate is subtracted and the frame is marked. When playback has asked for a sample, the controller must deliver it during the next frame. If it does not, the block keeps the last sample, records a sticky underrun, and software reads and clears that record.

Top module: `vrate_pacer`

## Requirements
- R1: After reset, both rate registers read 48000 (BB80h), the underrun status reads 0, and `play_req` and `cap_valid` are low.
- R2: The register address map is 0 = playback rate, 1 = capture rate, 2 = status (bit 0 = underrun, other bits 0). A read presents its data on `reg_rdata` in the cycle after `reg_rd`. Writing one of the supported codes 1F40h (8000), 2B11h (11025), 3E80h (16000), 5622h (22050), AC44h (44100) or BB80h (48000) reads back unchanged.
- R3: Any other written value is stored and read back as the nearest supported rate. A value exactly halfway between two supported rates stores the lower of the two.
- R4: The playback request level for a frame is updated on each frame strobe and holds until the next strobe. Counting frames from reset or from the last write to the playback rate, frame n carries a request exactly when floor(n·rate/48000) exceeds floor((n−1)·rate/48000). At 48000 every frame carries a request.
- R5: At 44100, exactly 441 of every 480 consecutive frames after a rate write carry a playback request.
- R6: `cap_valid` follows the rule of R4 using the capture rate. It is independent of the playback rate, and one flag serves both capture channels.
- R7: When the previous frame carried a request, the first `play_din_valid` in the current frame loads `play_din` into `play_dout`, which is visible on the next cycle. Any later data in that same frame is ignored.
- R8: If a frame that follows a request ends without data, the underrun flag is set and stays set, and `play_dout` keeps its previous value.
- R9: Reading the status address returns the underrun flag and clears it. Writes to the status address have no effect.
- R10: Writing a rate register restarts that direction's accumulator from zero and leaves the other direction's pacing untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| frame_tick | input | 1 | One-cycle pulse at each link frame start |
| play_req | output | 1 | Current frame asks the controller for a playback sample |
| play_din_valid | input | 1 | Playback sample present on play_din |
| play_din | input | SAMPLE_W | Playback sample from the controller |
| play_dout | output | SAMPLE_W | Sample held for the playback converter |
| cap_valid | output | 1 | Current frame carries a new capture sample pair |

## Verification
The hardest case to reach is the restart rule combined with independence. The aim is to show that rewriting the playback rate in the middle of a run resets only the playback accumulator, while capture continues on its own phase. The bench runs both directions at different rates and rewrites the playback rate partway through. It then checks that the playback pattern starts over from frame one and that the capture pattern continues without a break. Underrun is reached by arranging one requested frame that is fed and one that is not, and then reading the status twice.

// File: rtl/vrate_pkg.sv
package vrate_pkg;

    localparam int RATE_W    = 16;
    localparam int LINK_HZ   = 48000;
    localparam int NUM_RATES = 6;
    localparam int NUM_DIRS  = 2;
    localparam int DIR_PLAY  = 0;
    localparam int DIR_CAP   = 1;

    typedef logic [RATE_W-1:0] rate_t;

    typedef enum logic [1:0] {
        ADDR_PLAY = 2'd0,
        ADDR_CAP  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic      wr;
        logic      rd;
        reg_addr_e addr;
        rate_t     wdata;
    } reg_req_t;

    localparam rate_t RATE_RESET = 16'hBB80;

    // Supported rates in ascending order; the order makes ties pick the lower.
    function automatic rate_t rate_entry(input int idx);
        rate_t r;
        case (idx)
            0:       r = 16'h1F40;
            1:       r = 16'h2B11;
            2:       r = 16'h3E80;
            3:       r = 16'h5622;
            4:       r = 16'hAC44;
            default: r = 16'hBB80;
        endcase
        return r;
    endfunction

    function automatic rate_t snap_rate(input rate_t wval);
        int    best_d;
        int    d;
        rate_t best;
        best_d = 32'h7FFF_FFFF;
        best   = RATE_RESET;
        for (int i = 0; i < NUM_RATES; i++) begin
            d = int'(wval) - int'(rate_entry(i));
            if (d < 0) d = -d;
            if (d < best_d) begin
                best_d = d;
                best   = rate_entry(i);
            end
        end
        return best;
    endfunction

    function automatic logic is_supported(input rate_t r);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_RATES; i++)
            if (r == rate_entry(i)) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/vrate_regs.sv
module vrate_regs
    import vrate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_req_t req,
    input  logic     underrun_set,
    output rate_t    play_rate,
    output rate_t    cap_rate,
    output logic     play_clr,
    output logic     cap_clr,
    output logic     underrun_q,
    output rate_t    rdata
);

    logic  stat_rd;
    rate_t rd_mux;
    rate_t snapped;

    assign snapped  = snap_rate(req.wdata);
    assign play_clr = req.wr && (req.addr == ADDR_PLAY);
    assign cap_clr  = req.wr && (req.addr == ADDR_CAP);
    assign stat_rd  = req.rd && (req.addr == ADDR_STAT);

    always_comb begin
        case (req.addr)
            ADDR_PLAY: rd_mux = play_rate;
            ADDR_CAP:  rd_mux = cap_rate;
            ADDR_STAT: rd_mux = {{(RATE_W-1){1'b0}}, underrun_q};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            play_rate  <= RATE_RESET;
            cap_rate   <= RATE_RESET;
            underrun_q <= 1'b0;
            rdata      <= '0;
        end else begin
            if (play_clr) play_rate <= snapped;
            if (cap_clr)  cap_rate  <= snapped;
            if (req.rd)   rdata     <= rd_mux;
            underrun_q <= underrun_set | (underrun_q & ~stat_rd);
        end
    end

endmodule

// File: rtl/vrate_accum.sv
module vrate_accum
    import vrate_pkg::*;
#(
    parameter int LINK = LINK_HZ,
    parameter int AW   = $clog2(2 * LINK)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame,
    input  logic          clr,
    input  rate_t         rate,
    output logic          fire_q,
    output logic [AW-1:0] acc_q
);

    localparam logic [AW:0] LINK_V = (AW + 1)'(LINK);

    logic [AW:0] sum;

    assign sum = {1'b0, acc_q} + (AW + 1)'(rate);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            fire_q <= 1'b0;
        end else if (clr) begin
            acc_q  <= '0;
        end else if (frame) begin
            if (sum >= LINK_V) begin
                acc_q  <= AW'(sum - LINK_V);
                fire_q <= 1'b1;
            end else begin
                acc_q  <= AW'(sum);
                fire_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vrate_consume.sv
module vrate_consume #(
    parameter int SW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame,
    input  logic          req_level,
    input  logic          din_valid,
    input  logic [SW-1:0] din,
    output logic [SW-1:0] dout,
    output logic          awaiting_q,
    output logic          got_q,
    output logic          underrun_set
);

    logic take;

    assign take         = awaiting_q && !got_q && din_valid;
    assign underrun_set = frame && awaiting_q && !got_q && !din_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            awaiting_q <= 1'b0;
            got_q      <= 1'b0;
            dout       <= '0;
        end else begin
            if (take) dout <= din;
            if (frame) begin
                awaiting_q <= req_level;
                got_q      <= 1'b0;
            end else if (take) begin
                got_q      <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vrate_pacer.sv
module vrate_pacer
    import vrate_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int LINK     = LINK_HZ,
    localparam int ACC_W   = $clog2(2 * LINK)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [1:0]          reg_addr,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    input  logic                frame_tick,
    output logic                play_req,
    input  logic                play_din_valid,
    input  logic [SAMPLE_W-1:0] play_din,
    output logic [SAMPLE_W-1:0] play_dout,
    output logic                cap_valid
);

    reg_req_t   req;
    rate_t      rate_arr [NUM_DIRS];
    logic       clr_arr  [NUM_DIRS];
    logic       fire_arr [NUM_DIRS];
    logic [ACC_W-1:0] acc_arr [NUM_DIRS];
    logic       underrun_set;
    logic       underrun_q;
    logic       awaiting_q;
    logic       got_q;

    assign req = '{wr: reg_wr, rd: reg_rd, addr: reg_addr_e'(reg_addr), wdata: reg_wdata};

    vrate_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .underrun_set (underrun_set),
        .play_rate    (rate_arr[DIR_PLAY]),
        .cap_rate     (rate_arr[DIR_CAP]),
        .play_clr     (clr_arr[DIR_PLAY]),
        .cap_clr      (clr_arr[DIR_CAP]),
        .underrun_q   (underrun_q),
        .rdata        (reg_rdata)
    );

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
        vrate_accum #(.LINK(LINK), .AW(ACC_W)) u_acc (
            .clk    (clk),
            .rst    (rst),
            .frame  (frame_tick),
            .clr    (clr_arr[d]),
            .rate   (rate_arr[d]),
            .fire_q (fire_arr[d]),
            .acc_q  (acc_arr[d])
        );
    end

    assign play_req  = fire_arr[DIR_PLAY];
    assign cap_valid = fire_arr[DIR_CAP];

    vrate_consume #(.SW(SAMPLE_W)) u_consume (
        .clk          (clk),
        .rst          (rst),
        .frame        (frame_tick),
        .req_level    (play_req),
        .din_valid    (play_din_valid),
        .din          (play_din),
        .dout         (play_dout),
        .awaiting_q   (awaiting_q),
        .got_q        (got_q),
        .underrun_set (underrun_set)
    );

endmodule

// File: rtl/vrate_pacer_chk.sv
module vrate_pacer_chk
    import vrate_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int LINK     = LINK_HZ,
    parameter int ACC_W    = 17
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_rd,
    input logic [1:0]          reg_addr,
    input logic                frame_tick,
    input logic                play_req,
    input logic                cap_valid,
    input logic                play_din_valid,
    input logic [SAMPLE_W-1:0] play_din,
    input logic [SAMPLE_W-1:0] play_dout,
    input rate_t               play_rate,
    input rate_t               cap_rate,
    input logic [ACC_W-1:0]    play_acc,
    input logic [ACC_W-1:0]    cap_acc,
    input logic                underrun_q,
    input logic                awaiting_q,
    input logic                got_q
);

    AST_RESET_RATES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (play_rate == RATE_RESET && cap_rate == RATE_RESET && !underrun_q)); // R1

    AST_RATE_SUPPORTED: assert property (@(posedge clk) disable iff (rst)
        is_supported(play_rate) && is_supported(cap_rate)); // R3

    AST_PLAY_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(play_acc) < LINK); // R4

    AST_PLAY_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(play_req)); // R4

    AST_CAP_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cap_acc) < LINK); // R6

    AST_CAP_VALID_HELD: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(cap_valid)); // R6

    AST_SAMPLE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (play_din_valid && awaiting_q && !got_q) |=> (play_dout == $past(play_din))); // R7

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !play_din_valid |=> $stable(play_dout)); // R8

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (underrun_q && !(reg_rd && reg_addr == 2'd2)) |=> underrun_q); // R9

endmodule

bind vrate_pacer vrate_pacer_chk #(.SAMPLE_W(SAMPLE_W), .LINK(LINK), .ACC_W(ACC_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_rd         (reg_rd),
    .reg_addr       (reg_addr),
    .frame_tick     (frame_tick),
    .play_req       (play_req),
    .cap_valid      (cap_valid),
    .play_din_valid (play_din_valid),
    .play_din       (play_din),
    .play_dout      (play_dout),
    .play_rate      (rate_arr[0]),
    .cap_rate       (rate_arr[1]),
    .play_acc       (acc_arr[0]),
    .cap_acc        (acc_arr[1]),
    .underrun_q     (underrun_q),
    .awaiting_q     (awaiting_q),
    .got_q          (got_q)
);

// File: tb/vrate_pacer_tb.sv
`timescale 1ns/1ps
module vrate_pacer_tb;

    localparam int SW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [15:0]   reg_wdata = 16'd0;
    logic [15:0]   reg_rdata;
    logic          frame_tick = 1'b0;
    logic          play_req;
    logic          play_din_valid = 1'b0;
    logic [SW-1:0] play_din = '0;
    logic [SW-1:0] play_dout;
    logic          cap_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vrate_pacer #(.SAMPLE_W(SW)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
        .play_req(play_req), .play_din_valid(play_din_valid), .play_din(play_din),
        .play_dout(play_dout), .cap_valid(cap_valid)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
    endtask

    task automatic feed(input logic [SW-1:0] d);
        @(negedge clk); play_din_valid = 1'b1; play_din = d;
        @(negedge clk); play_din_valid = 1'b0;
    endtask

    function automatic bit expect_fire(input longint n, input longint rate);
        return ((n * rate) / 48000) != (((n - 1) * rate) / 48000);
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        check("R1 play_req", play_req, 0);
        check("R1 cap_valid", cap_valid, 0);
        rd_reg(2'd0, v); check("R1 play rate", v, 16'hBB80);
        rd_reg(2'd1, v); check("R1 cap rate", v, 16'hBB80);
        rd_reg(2'd2, v); check("R1 status", v, 0);
    endtask

    task automatic t_codes();
        logic [15:0] v;
        logic [15:0] codes [6] = '{16'h1F40, 16'h2B11, 16'h3E80, 16'h5622, 16'hAC44, 16'hBB80};
        foreach (codes[i]) begin
            wr_reg(2'd1, codes[i]); rd_reg(2'd1, v); check("R2 supported code", v, codes[i]);
        end
    endtask

    task automatic t_snap();
        logic [15:0] v;
        logic [15:0] wv [7] = '{16'd19025, 16'd9000, 16'd0, 16'hFFFF, 16'd46050, 16'd46051, 16'd33075};
        logic [15:0] ev [7] = '{16'h3E80, 16'h1F40, 16'h1F40, 16'hBB80, 16'hAC44, 16'hBB80, 16'h5622};
        foreach (wv[i]) begin
            wr_reg(2'd0, wv[i]); rd_reg(2'd0, v); check("R3 snapped rate", v, ev[i]);
        end
    endtask

    task automatic t_pace(input logic [15:0] code, input int frames, input string tag);
        int hits = 0;
        wr_reg(2'd0, code);
        for (int n = 1; n <= frames; n++) begin
            tick();
            check(tag, play_req, expect_fire(n, code));
            if (play_req) hits++;
        end
        if (code == 16'hAC44) check("R5 requests per 480 frames", hits, 441);
    endtask

    task automatic t_independent();
        int pn = 0;
        int cn = 0;
        wr_reg(2'd1, 16'h1F40);
        wr_reg(2'd0, 16'h5622);
        for (int n = 0; n < 30; n++) begin
            tick(); pn++; cn++;
            check("R4 play at 22050", play_req, expect_fire(pn, 22050));
            check("R6 cap at 8000", cap_valid, expect_fire(cn, 8000));
        end
        wr_reg(2'd0, 16'h5622);
        pn = 0;
        for (int n = 0; n < 12; n++) begin
            tick(); pn++; cn++;
            check("R10 play restarted", play_req, expect_fire(pn, 22050));
            check("R10 cap continues", cap_valid, expect_fire(cn, 8000));
        end
    endtask

    task automatic t_underrun();
        logic [15:0] v;
        wr_reg(2'd0, 16'hBB80);
        tick(); feed(20'h11111);
        tick(); feed(20'h2A5C3);
        check("R7 sample loaded", play_dout, 20'h2A5C3);
        rd_reg(2'd2, v);
        rd_reg(2'd2, v); check("R9 status clear", v, 0);
        wr_reg(2'd2, 16'h0001);
        rd_reg(2'd2, v); check("R9 status write ignored", v, 0);
        tick(); feed(20'h0C0DE); feed(20'h0BEEF);
        check("R7 second sample ignored", play_dout, 20'h0C0DE);
        tick();
        tick();
        check("R8 sample held", play_dout, 20'h0C0DE);
        rd_reg(2'd2, v); check("R8 underrun set", v, 1);
        rd_reg(2'd2, v); check("R9 cleared on read", v, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_codes();
        t_snap();
        t_pace(16'hBB80, 20, "R4 every frame at 48000");
        t_pace(16'hAC44, 480, "R5 44100 pattern");
        t_pace(16'h2B11, 100, "R4 11025 pattern");
        t_independent();
        t_underrun();
        finish_run();
    end

endmodule